// File: doc/BRIEF.md
# Three-Zone Asynchronous External Bus Controller

This block connects a simple internal request port to an asynchronous external memory bus. The bus has a 20-bit address, a 32-bit data path, separate active-low read and write strobes, a data output enable and three active-low chip selects. Each access is steered to one of three address zones by the top three bits of the internal address. Each zone has its own timing:

- a setup phase, where the chip select is low and the strobe is still high,
- an active phase, where the strobe is low,
- a hold phase, where the strobe is high again and the chip select is still low.

A zone can also be set to wait for an external ready line before it ends the active phase. This lets slow memories and peripherals connect without glue logic.

A request is accepted only while the sequencer is idle. The zone's timing is copied at that moment. The block runs the strobe sequence and then pulses `done`. On a read, the captured data is presented on `rdata` in the same cycle as the `done` pulse. An address whose top bits match no zone gets an error response, and no external cycle is started. Timing is programmed through a small write-only configuration port.

Top module: `xbus_zone_ctrl`

## Requirements
- R1: Zone decode uses the top 3 bits of the 23-bit `req_addr`. 3'b000 drives `ext_cs_n[0]` low, 3'b110 drives `ext_cs_n[1]` low and 3'b111 drives `ext_cs_n[2]` low. At most one chip select is low at any time.
- R2: A request whose top bits are any other value pulses `done` and `err` together in the cycle after acceptance. It asserts no chip select and no strobe.
- R3: Each access begins with a setup phase of setup+1 cycles. During it the zone's chip select is low and both strobes are high.
- R4: The setup phase is followed by an active phase. With ready waiting off, it lasts wait+1 cycles. During it `ext_rd_n` is low for reads or `ext_wr_n` is low for writes, never both.
- R5: The active phase is followed by a hold phase of hold+1 cycles. During it the strobes are high and the chip select is still low. `done` pulses in the next cycle, with all chip selects high.
- R6: When a zone's ready option is on, the active phase ends only when two conditions hold: its wait count has expired, and `ext_ready` has been registered high on two consecutive clocks. A ready raised during active cycle K ends the phase after max(wait+1, K+2) cycles.
- R7: On a read, `ext_din` is captured on the last active cycle and held on `rdata` from the `done` cycle onward. `ext_doe` stays low for the whole read.
- R8: On a write, `ext_doe` is high and `ext_dout` equals the request's write data for every cycle the chip select is low. On every access, `ext_addr` equals the low 20 request-address bits and stays stable while the chip select is low.
- R9: A `cfg_we` pulse writes `cfg_data` into the zone chosen by `cfg_zone` (0 = zone 0, 1 = zone 6, 2 = zone 7; value 3 is ignored). The fields are setup in bits [2:0], wait in [7:3], hold in [10:8] and ready enable in bit [11]. The reset values are setup 7, wait 31, hold 7 and ready off.
- R10: A configuration write during an access does not change that access's timing. The new values apply from the next accepted request.
- R11: `busy` is high from the cycle after acceptance through the last hold cycle, and is low in the `done` cycle. A request presented while busy is ignored and is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Zone bits [22:20], external address [19:0] |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Unmapped-zone flag, pulses with done |
| rdata | output | 32 | Captured read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_zone | input | 2 | Configuration target zone |
| cfg_data | input | 12 | Packed setup, wait, hold and ready-enable fields |
| ext_addr | output | 20 | External address |
| ext_cs_n | output | 3 | Active-low chip selects for zones 0, 6, 7 |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 1 | Active-low write strobe |
| ext_dout | output | 32 | Write data to the bus |
| ext_doe | output | 1 | Data bus output enable |
| ext_din | input | 32 | Read data from the bus |
| ext_ready | input | 1 | External ready, asynchronous |

## Verification
The bench measures the length of each phase from the pins and compares it with the programmed counts. An off-by-one in the setup, wait or hold counter would show up as a phase that is one cycle too long or too short.

Read data on the bus changes on every active cycle, so capturing one cycle early or late returns the wrong word. The ready tests raise the line late, raise it early with a longer wait count, and hold it high from the start. A design that used the ready line without the two-stage register, or that ignored the wait count, would end the active phase at the wrong cycle.

Configuration writes and a second request arrive in the middle of an access. A design that reads live configuration would bend the running access, and one that queued the request would start a second cycle on a different chip select.

// File: rtl/xbus_zone_ctrl.sv
module xbus_zone_ctrl #(
  parameter int AW = 20,
  parameter int DW = 32,
  parameter int SW = 3,
  parameter int WW = 5,
  parameter int HW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW+2:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DW-1:0]     rdata,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_zone,
  input  logic [SW+WW+HW:0] cfg_data,
  output logic [AW-1:0]     ext_addr,
  output logic [2:0]        ext_cs_n,
  output logic              ext_rd_n,
  output logic              ext_wr_n,
  output logic [DW-1:0]     ext_dout,
  output logic              ext_doe,
  input  logic [DW-1:0]     ext_din,
  input  logic              ext_ready
);
  localparam int CW   = SW + WW + HW + 1;
  localparam int MX   = (SW > HW) ? SW : HW;
  localparam int CNTW = (WW > MX) ? WW : MX;

  typedef enum logic [1:0] {IDLE, LEAD, ACT, TRAIL} st_t;

  st_t             st;
  logic [CNTW-1:0] cnt;
  logic [CW-1:0]   cfg_q [3];
  logic [CW-1:0]   sel_cfg;
  logic [1:0]      zidx, zone_q;
  logic            hit, wr_q, rdy_q, r1, r2;
  logic [WW-1:0]   wait_q;
  logic [HW-1:0]   hold_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   wdata_q;
  logic [2:0]      ztop;

  for (genvar z = 0; z < 3; z++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_q[z] <= {1'b0, {HW{1'b1}}, {WW{1'b1}}, {SW{1'b1}}};
      else if (cfg_we && cfg_zone == 2'(z))
        cfg_q[z] <= cfg_data;
    end
  end

  assign ztop    = req_addr[AW+2:AW];
  assign hit     = (ztop == 3'b000) || (ztop == 3'b110) || (ztop == 3'b111);
  assign zidx    = (ztop == 3'b000) ? 2'd0 : (ztop == 3'b110) ? 2'd1 : 2'd2;
  assign sel_cfg = (zidx == 2'd0) ? cfg_q[0] : (zidx == 2'd1) ? cfg_q[1] : cfg_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r1 <= 1'b0;
      r2 <= 1'b0;
    end else begin
      r1 <= ext_ready;
      r2 <= r1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      cnt     <= '0;
      done    <= 1'b0;
      err     <= 1'b0;
      rdata   <= '0;
      zone_q  <= 2'd0;
      wr_q    <= 1'b0;
      rdy_q   <= 1'b0;
      wait_q  <= '0;
      hold_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (st)
        IDLE: if (req_valid) begin
          if (hit) begin
            st      <= LEAD;
            cnt     <= CNTW'(sel_cfg[SW-1:0]);
            wait_q  <= sel_cfg[SW+WW-1:SW];
            hold_q  <= sel_cfg[SW+WW+HW-1:SW+WW];
            rdy_q   <= sel_cfg[CW-1];
            zone_q  <= zidx;
            wr_q    <= req_write;
            addr_q  <= req_addr[AW-1:0];
            wdata_q <= req_wdata;
          end else begin
            done <= 1'b1;
            err  <= 1'b1;
          end
        end
        LEAD: if (cnt == '0) begin
          st  <= ACT;
          cnt <= CNTW'(wait_q);
        end else cnt <= cnt - CNTW'(1);
        ACT: if (cnt != '0) cnt <= cnt - CNTW'(1);
        else if (!rdy_q || (r1 && r2)) begin
          st  <= TRAIL;
          cnt <= CNTW'(hold_q);
          if (!wr_q) rdata <= ext_din;
        end
        TRAIL: if (cnt == '0) begin
          st   <= IDLE;
          done <= 1'b1;
        end else cnt <= cnt - CNTW'(1);
        default: st <= IDLE;
      endcase
    end
  end

  assign busy        = (st != IDLE);
  assign ext_cs_n[0] = !(busy && zone_q == 2'd0);
  assign ext_cs_n[1] = !(busy && zone_q == 2'd1);
  assign ext_cs_n[2] = !(busy && zone_q == 2'd2);
  assign ext_rd_n    = !(st == ACT && !wr_q);
  assign ext_wr_n    = !(st == ACT && wr_q);
  assign ext_doe     = busy && wr_q;
  assign ext_dout    = wdata_q;
  assign ext_addr    = addr_q;
endmodule

// File: rtl/xbus_zone_ctrl_chk.sv
module xbus_zone_ctrl_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [AW-1:0] ext_addr,
  input logic [2:0]    ext_cs_n,
  input logic          ext_rd_n,
  input logic          ext_wr_n,
  input logic          ext_doe
);
  AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~ext_cs_n)); // R1
  AST_ERR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (ext_cs_n == 3'h7 && $past(ext_cs_n) == 3'h7 && done)); // R2
  AST_LEAD_BEFORE_RD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_rd_n) |-> $past(ext_cs_n) != 3'h7); // R3
  AST_LEAD_BEFORE_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_wr_n) |-> $past(ext_cs_n) != 3'h7); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!ext_rd_n && !ext_wr_n)); // R4
  AST_TRAIL_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ext_rd_n) || $rose(ext_wr_n)) |-> ext_cs_n != 3'h7); // R5
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_rd_n |-> !ext_doe); // R7
  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_wr_n |-> ext_doe); // R8
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_cs_n != 3'h7 && $past(ext_cs_n) == ext_cs_n) |-> $stable(ext_addr)); // R8
  AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    ext_cs_n != 3'h7 |-> busy); // R11
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
endmodule

bind xbus_zone_ctrl xbus_zone_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .ext_addr(ext_addr), .ext_cs_n(ext_cs_n), .ext_rd_n(ext_rd_n),
  .ext_wr_n(ext_wr_n), .ext_doe(ext_doe)
);

// File: tb/sim_xbus_zone_ctrl.sv
`timescale 1ns/1ps
module sim_xbus_zone_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 0, req_write = 0;
  logic [22:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, err;
  logic [31:0] rdata;
  logic        cfg_we = 0;
  logic [1:0]  cfg_zone = '0;
  logic [11:0] cfg_data = '0;
  logic [19:0] ext_addr;
  logic [2:0]  ext_cs_n;
  logic        ext_rd_n, ext_wr_n, ext_doe;
  logic [31:0] ext_dout;
  logic [31:0] ext_din = '0;
  logic        ext_ready = 0;

  int n_tests = 0, n_fail = 0;
  int nlead, nact, ntrail;
  logic [2:0]  cs_seen;
  logic        saw_rd, saw_wr, doe_bad, dout_bad, addr_bad, busy_bad, got_err, end_bad;
  logic [31:0] got_rdata;
  int          rdy_k;
  logic        inject;

  always #2.5 clk = ~clk;

  xbus_zone_ctrl u0 (.*);

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] mk(input int s, input int w, input int h, input bit r);
    return {r, 3'(h), 5'(w), 3'(s)};
  endfunction

  task automatic cfg(input logic [1:0] z, input logic [11:0] d);
    @(negedge clk); cfg_we = 1; cfg_zone = z; cfg_data = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic access(input logic [22:0] a, input logic w, input logic [31:0] d);
    @(negedge clk); req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 0;
    nlead = 0; nact = 0; ntrail = 0; cs_seen = 0;
    saw_rd = 0; saw_wr = 0; doe_bad = 0; dout_bad = 0; addr_bad = 0; busy_bad = 0;
    got_err = 0; end_bad = 0;
    for (int i = 0; i < 400; i++) begin
      cfg_we = 0;
      if (i > 0) req_valid = 0;
      if (done) begin
        got_rdata = rdata; got_err = err;
        end_bad = busy || (ext_cs_n != 3'h7);
        break;
      end
      if (ext_cs_n != 3'h7) begin
        cs_seen |= ~ext_cs_n;
        if (!busy) busy_bad = 1;
        if (ext_addr != a[19:0]) addr_bad = 1;
        if (ext_doe != w) doe_bad = 1;
        if (w && ext_dout != d) dout_bad = 1;
        if (!ext_rd_n || !ext_wr_n) begin
          nact++;
          saw_rd |= !ext_rd_n; saw_wr |= !ext_wr_n;
          ext_din = 32'hA000_0000 + 32'(nact);
          if (rdy_k > 0 && nact == rdy_k) ext_ready = 1;
        end else if (nact == 0) begin
          nlead++;
          if (inject && nlead == 1) begin
            cfg_we = 1; cfg_zone = 2'd0; cfg_data = mk(3, 0, 1, 0);
            req_valid = 1; req_write = 0; req_addr = {3'b111, 20'h1};
          end
        end else ntrail++;
      end
      @(negedge clk);
    end
    cfg_we = 0; req_valid = 0; inject = 0; rdy_k = 0;
  endtask

  task automatic chk_phases(input string r, input int el, input int ea, input int et, input logic [2:0] ecs);
    chk(nlead == el, r, "setup cycles", nlead, el);
    chk(nact == ea, r, "active cycles", nact, ea);
    chk(ntrail == et, r, "hold cycles", ntrail, et);
    chk(cs_seen == ecs, r, "chip select mask", cs_seen, ecs);
    chk(!end_bad && !busy_bad, r, "busy/cs at done", end_bad, 0);
  endtask

  task automatic t_reset;
    chk(ext_cs_n == 3'h7 && ext_rd_n && ext_wr_n, "R1", "reset strobes", {ext_cs_n, ext_rd_n, ext_wr_n}, 31);
    chk(!busy && !done && !ext_doe, "R11", "reset busy/done/doe", {busy, done, ext_doe}, 0);
  endtask

  task automatic t_defaults; // R9 reset timing
    access({3'b111, 20'h12345}, 0, 0);
    chk_phases("R9", 8, 32, 8, 3'b100);
  endtask

  task automatic t_read; // R1 R3 R4 R5 R7
    cfg(2'd0, mk(1, 2, 0, 0));
    access({3'b000, 20'hABCDE}, 0, 0);
    chk_phases("R3", 2, 3, 1, 3'b001);
    chk(got_rdata == 32'hA000_0003, "R7", "read data from last active cycle", got_rdata, 32'hA000_0003);
    chk(!doe_bad && saw_rd && !saw_wr, "R7", "read strobe only, no drive", {doe_bad, saw_rd, saw_wr}, 2);
    chk(!addr_bad, "R8", "address on read", addr_bad, 0);
  endtask

  task automatic t_write; // R1 R4 R5 R8
    cfg(2'd1, mk(0, 0, 2, 0));
    access({3'b110, 20'h0F0F0}, 1, 32'hDEAD_BEEF);
    chk_phases("R5", 1, 1, 3, 3'b010);
    chk(!doe_bad && !dout_bad && !addr_bad, "R8", "write drive/data/addr", {doe_bad, dout_bad, addr_bad}, 0);
    chk(saw_wr && !saw_rd, "R4", "write strobe only", {saw_wr, saw_rd}, 2);
  endtask

  task automatic t_unmapped; // R2
    access({3'b011, 20'h00001}, 0, 0);
    chk(got_err && cs_seen == 0 && (nlead + nact + ntrail) == 0, "R2", "err, no cs",
        {got_err, cs_seen}, 8);
  endtask

  task automatic t_ready; // R6
    cfg(2'd2, mk(0, 2, 0, 1));
    ext_ready = 0; rdy_k = 4;
    access({3'b111, 20'h00010}, 0, 0);
    chk(nact == 6, "R6", "late ready active cycles", nact, 6);
    ext_ready = 1;
    cfg(2'd2, mk(0, 4, 0, 1));
    access({3'b111, 20'h00020}, 0, 0);
    chk(nact == 5, "R6", "early ready waits for count", nact, 5);
    cfg(2'd2, mk(0, 0, 0, 1));
    access({3'b111, 20'h00030}, 0, 0);
    chk(nact == 1, "R6", "ready high from start", nact, 1);
    ext_ready = 0;
  endtask

  task automatic t_midcfg; // R10 R11
    cfg(2'd0, mk(1, 2, 0, 0));
    inject = 1;
    access({3'b000, 20'h00040}, 0, 0);
    chk_phases("R10", 2, 3, 1, 3'b001);
    repeat (3) @(negedge clk);
    chk(!busy && ext_cs_n == 3'h7, "R11", "request during busy not queued", {busy, ext_cs_n}, 7);
    access({3'b000, 20'h00050}, 0, 0);
    chk_phases("R10", 4, 1, 2, 3'b001);
  endtask

  initial begin
    inject = 0; rdy_k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_defaults();
    t_read();
    t_write();
    t_unmapped();
    t_ready();
    t_midcfg();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule